// File: doc/BRIEF.md
# Multi-Frame Receive Byte Buffer with Frame Rollback

This block is the receive-side byte store between a demodulator and a host or DMA engine. Bytes arrive one at a time while a frame is being received. A separate decision stage later accepts or rejects that frame with a strobe. The buffer holds up to 128 bytes and can contain any number of whole frames at once. Rejecting the frame in progress removes only that frame's bytes. Frames accepted earlier stay in place and remain readable.

Two write pointers separate the frame in progress from stored data. A speculative pointer moves with every stored byte. A committed pointer copies it when the frame is accepted, and the speculative pointer falls back to the committed one when the frame is rejected. Only committed bytes are visible on the read side.

Reads work like a data register: the head byte is shown on the read port, and a read strobe consumes it. A one-cycle request output tells a DMA channel that a byte is waiting. The status flags describe only this receive buffer, and no transmit or receive mode affects them.

Top module: `rxbuf_frame_fifo`

## Requirements
- R1: After reset or a flush strobe, st_nonempty, st_thresh, st_overflow and dma_req are 0 and rd_data is 0, and bytes stored before a flush are gone.
- R2: Bytes of a frame cannot be seen on the read side until frm_accept. After that, rd_data shows them in the order they were written, and each rd_en strobe moves to the next byte.
- R3: Several accepted frames are stored back to back and read out in sequence. Their total may reach 128 bytes.
- R4: frm_reject discards every byte written since the last accept, and nothing else. Bytes of earlier accepted frames stay readable and unchanged, and the freed space can be written again.
- R5: frm_start while a frame is still open (written but neither accepted nor rejected) discards that open frame's bytes before the new frame begins.
- R6: A write while the buffer already holds 128 bytes (committed plus open frame) is dropped and sets st_overflow. st_overflow stays 1, even after reads, until a flush strobe.
- R7: st_thresh is 1 while the buffer holds at least thresh bytes (committed plus open frame, thresh nonzero), or while at least one whole accepted frame has not been fully read. A frame counts as fully read once its last byte has been consumed.
- R8: dma_req is a one-cycle pulse in the cycle after the committed data goes from empty to non-empty. It also pulses in the cycle after each read that leaves committed data behind. It is never 1 while no committed data exists.
- R9: rd_en while no committed byte exists has no effect, and rd_data then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Store wr_data into the open frame this cycle |
| wr_data | input | DW | Received byte |
| frm_start | input | 1 | New frame begins; an unfinished open frame is discarded first |
| frm_accept | input | 1 | Commit the open frame (includes a byte written in the same cycle) |
| frm_reject | input | 1 | Discard the open frame (wins over frm_accept) |
| flush | input | 1 | Empty the whole buffer and clear the overflow flag |
| rd_en | input | 1 | Consume the byte shown on rd_data |
| rd_data | output | DW | Oldest committed byte, 0 when none |
| thresh | input | log2(DEPTH)+1 | Occupancy level for st_thresh; 0 disables the byte criterion |
| dma_req | output | 1 | One-cycle transfer request to a DMA channel |
| st_nonempty | output | 1 | At least one committed byte is unread |
| st_thresh | output | 1 | Occupancy at threshold or a whole frame waiting |
| st_overflow | output | 1 | Sticky: a byte was dropped because the buffer was full |

## Verification
The bench first drives single frames, with and without an accept, to check that open bytes are hidden and that accepted bytes come out in order. It then stores three frames of different lengths together, which shows that frame boundaries do not reorder or merge data. A reject after an accepted frame, followed by a frame that fills the buffer to exactly 128 bytes, shows the difference between rolling back only the open frame and clearing the whole buffer. A full buffer with one extra byte, and a threshold walked up by single bytes, then rejected, then re-filled by a short frame, show that overflow is counted from speculative occupancy and that the threshold flag reacts to both occupancy and whole frames.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // per-cycle frame control strobes, applied in order start, write, accept/reject
  typedef struct packed {
    logic start;
    logic accept;
    logic reject;
    logic flush;
  } rxf_ctl_t;
endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxf_ctl_t      ctl,
  input  logic          wr_valid,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic [PW-2:0] wr_addr,
  output logic          mark_set,
  output logic [PW-2:0] mark_addr,
  output logic [PW-2:0] head_addr,
  output logic          pop,
  output logic [PW-1:0] occ,
  output logic          nonempty,
  output logic          nonempty_nxt,
  output logic          ovf
);
  localparam int AW = PW - 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0] rd_q, com_q, spec_q;
  logic [PW-1:0] rd_n, com_n, spec_n;
  logic          ovf_q, ovf_n;
  logic [PW-1:0] spec_base, spec_w, spec_last;
  logic          full, keep, commit_evt;

  always_comb begin
    spec_base  = ctl.start ? com_q : spec_q;
    full       = (spec_base - rd_q) == FULL;
    wr_ok      = wr_valid && !full && !ctl.flush;
    spec_w     = spec_base + PW'(wr_ok);
    spec_last  = spec_w - PW'(1);
    keep       = ctl.accept && !ctl.reject;
    commit_evt = keep && (spec_w != com_q) && !ctl.flush;
    pop        = rd_en && (rd_q != com_q) && !ctl.flush;
    if (ctl.flush) begin
      rd_n   = '0;
      com_n  = '0;
      spec_n = '0;
      ovf_n  = 1'b0;
    end else begin
      rd_n   = rd_q + PW'(pop);
      com_n  = commit_evt ? spec_w : com_q;
      spec_n = ctl.reject ? com_q : spec_w;
      ovf_n  = ovf_q | (wr_valid && full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      com_q  <= '0;
      spec_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rd_q   <= rd_n;
      com_q  <= com_n;
      spec_q <= spec_n;
      ovf_q  <= ovf_n;
    end
  end

  assign wr_addr      = spec_base[AW-1:0];
  assign mark_set     = commit_evt;
  assign mark_addr    = spec_last[AW-1:0];
  assign head_addr    = rd_q[AW-1:0];
  assign occ          = spec_q - rd_q;
  assign nonempty     = rd_q != com_q;
  assign nonempty_nxt = rd_n != com_n;
  assign ovf          = ovf_q;

  // occupancy of the speculative region never exceeds capacity
  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);
  // committed data lies inside the speculative region
  assert_commit_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (com_q - rd_q) <= (spec_q - rd_q));
  // reject rolls the open frame back and leaves committed data alone
  assert_reject_rollback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.reject && !ctl.flush |=> (spec_q == $past(com_q)) && $stable(com_q));
  // overflow flag only leaves on flush
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !ctl.flush |=> ovf_q);
  // a read with nothing committed does not move the read side
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !nonempty && !ctl.flush |=> $stable(rd_q));
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          mark_set,
  input  logic [AW-1:0] mark_addr,
  input  logic [AW-1:0] head_addr,
  input  logic          head_valid,
  output logic [DW-1:0] rd_data,
  output logic          head_mark
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] last_q;

  // byte array, written only through its clock enable
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // end-of-frame marks: set on commit, cleared when the slot is rewritten
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (mark_set && (mark_addr == AW'(i)))
        last_q[i] <= 1'b1;
      else if (wr_en && (wr_addr == AW'(i)))
        last_q[i] <= 1'b0;
    end
  end

  assign rd_data   = head_valid ? mem[head_addr] : '0;
  assign head_mark = last_q[head_addr];
endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  logic          head_mark,
  input  logic          commit_evt,
  input  logic [PW-1:0] occ,
  input  logic [PW-1:0] thresh,
  input  logic          nonempty,
  input  logic          nonempty_nxt,
  output logic          st_thresh,
  output logic          dma_req
);
  logic [PW-1:0] frames_q, frames_n;
  logic          dma_q, dma_n;

  always_comb begin
    if (flush) begin
      frames_n = '0;
      dma_n    = 1'b0;
    end else begin
      frames_n = frames_q + PW'(commit_evt) - PW'(pop && head_mark);
      dma_n    = nonempty_nxt && (!nonempty || pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames_q <= '0;
      dma_q    <= 1'b0;
    end else begin
      frames_q <= frames_n;
      dma_q    <= dma_n;
    end
  end

  assign st_thresh = ((thresh != '0) && (occ >= thresh)) || (frames_q != '0);
  assign dma_req   = dma_q;

  // a request is only raised while committed data waits
  assert_dma_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> nonempty);
  // a whole unread frame implies unread committed bytes
  assert_frames_need_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frames_q != '0) |-> nonempty);
endmodule

// File: rtl/rxbuf_frame_fifo.sv
module rxbuf_frame_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [DW-1:0]          wr_data,
  input  logic                   frm_start,
  input  logic                   frm_accept,
  input  logic                   frm_reject,
  input  logic                   flush,
  input  logic                   rd_en,
  output logic [DW-1:0]          rd_data,
  input  logic [$clog2(DEPTH):0] thresh,
  output logic                   dma_req,
  output logic                   st_nonempty,
  output logic                   st_thresh,
  output logic                   st_overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  rxf_ctl_t      ctl;
  logic          wr_ok, mark_set, pop, nonempty, nonempty_nxt, head_mark;
  logic [AW-1:0] wr_addr, mark_addr, head_addr;
  logic [PW-1:0] occ;

  assign ctl = '{start: frm_start, accept: frm_accept,
                 reject: frm_reject, flush: flush};

  rxf_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wr_valid(wr_valid), .rd_en(rd_en),
    .wr_ok(wr_ok), .wr_addr(wr_addr), .mark_set(mark_set),
    .mark_addr(mark_addr), .head_addr(head_addr), .pop(pop), .occ(occ),
    .nonempty(nonempty), .nonempty_nxt(nonempty_nxt), .ovf(st_overflow)
  );

  rxf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
    .mark_set(mark_set), .mark_addr(mark_addr), .head_addr(head_addr),
    .head_valid(nonempty), .rd_data(rd_data), .head_mark(head_mark)
  );

  rxf_status #(.PW(PW)) u_stat (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop(pop),
    .head_mark(head_mark), .commit_evt(mark_set), .occ(occ),
    .thresh(thresh), .nonempty(nonempty), .nonempty_nxt(nonempty_nxt),
    .st_thresh(st_thresh), .dma_req(dma_req)
  );

  assign st_nonempty = nonempty;

  // overflow flag rises only on a write attempt
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overflow) |-> $past(wr_valid));
endmodule

// File: tb/tb_rxbuf_frame_fifo.sv
`timescale 1ns/1ps
module tb_rxbuf_frame_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 0, frm_start = 0, frm_accept = 0, frm_reject = 0;
  logic       flush = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] thresh = 0;
  logic [7:0] rd_data;
  logic       dma_req, st_nonempty, st_thresh, st_overflow;

  int total = 0;
  int bad = 0;
  byte unsigned exp_q[$];   // committed bytes, scoreboard
  byte unsigned pend_q[$];  // open frame

  always #2.5 clk = ~clk;

  rxbuf_frame_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .frm_start(frm_start), .frm_accept(frm_accept), .frm_reject(frm_reject),
    .flush(flush), .rd_en(rd_en), .rd_data(rd_data), .thresh(thresh),
    .dma_req(dma_req), .st_nonempty(st_nonempty), .st_thresh(st_thresh),
    .st_overflow(st_overflow)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input byte unsigned d);
    wr_valid = 1; wr_data = d;
    if (exp_q.size() + pend_q.size() < 128) pend_q.push_back(d);
    cyc();
    wr_valid = 0;
  endtask

  task automatic wr_frame(input int n, input byte unsigned seed);
    for (int i = 0; i < n; i++) wr(byte'(seed + i));
  endtask

  task automatic accept();
    frm_accept = 1; cyc(); frm_accept = 0;
    foreach (pend_q[i]) exp_q.push_back(pend_q[i]);
    pend_q.delete();
  endtask

  task automatic reject();
    frm_reject = 1; cyc(); frm_reject = 0;
    pend_q.delete();
  endtask

  task automatic do_flush();
    flush = 1; cyc(); flush = 0;
    exp_q.delete(); pend_q.delete();
  endtask

  // monitor step: compare head byte with scoreboard, then consume it
  task automatic rd_n(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      byte unsigned e;
      e = exp_q.pop_front();
      chk(st_nonempty == 1'b1, rq, st_nonempty, 1);
      chk(rd_data == e, rq, rd_data, e);
      rd_en = 1; cyc(); rd_en = 0;
      chk(dma_req == (exp_q.size() > 0), "R8", dma_req, exp_q.size() > 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(st_nonempty == 0, "R1", st_nonempty, 0);
    chk(st_thresh == 0, "R1", st_thresh, 0);
    chk(st_overflow == 0, "R1", st_overflow, 0);
    chk(dma_req == 0, "R1", dma_req, 0);
    chk(rd_data == 0, "R1", rd_data, 0);

    // R9 read while empty
    rd_en = 1; cyc(); rd_en = 0;
    chk(st_nonempty == 0 && rd_data == 0, "R9", rd_data, 0);

    // R2 open frame hidden, then visible in order; R8 pulse
    frm_start = 1; cyc(); frm_start = 0;
    wr_frame(3, 8'h10);
    chk(st_nonempty == 0, "R2", st_nonempty, 0);
    chk(dma_req == 0, "R8", dma_req, 0);
    accept();
    chk(dma_req == 1, "R8", dma_req, 1);
    cyc();
    chk(dma_req == 0, "R8", dma_req, 0);
    rd_n(3, "R2");
    chk(st_nonempty == 0, "R2", st_nonempty, 0);

    // R3 three frames together
    wr_frame(10, 8'h20); accept();
    wr_frame(20, 8'h40); accept();
    wr_frame(30, 8'h80); accept();
    chk(st_thresh == 1, "R7", st_thresh, 1);
    rd_n(60, "R3");
    chk(st_thresh == 0, "R7", st_thresh, 0);

    // R4 reject drops only the open frame, space reused to 128
    wr_frame(5, 8'hA0); accept();
    wr_frame(7, 8'hC0); reject();
    chk(st_nonempty == 1, "R4", st_nonempty, 1);
    wr_frame(123, 8'h01); accept();
    chk(st_overflow == 0, "R4", st_overflow, 0);
    rd_n(128, "R4");
    chk(st_nonempty == 0, "R4", st_nonempty, 0);

    // R5 start during open frame discards it
    wr_frame(4, 8'h55);
    frm_start = 1; cyc(); frm_start = 0; pend_q.delete();
    wr_frame(3, 8'h66); accept();
    rd_n(3, "R5");
    chk(st_nonempty == 0, "R5", st_nonempty, 0);

    // R6 overflow drop and stickiness
    wr_frame(128, 8'h03);
    chk(st_overflow == 0, "R6", st_overflow, 0);
    wr(8'hEE);
    chk(st_overflow == 1, "R6", st_overflow, 1);
    accept();
    rd_n(128, "R6");
    chk(st_overflow == 1, "R6", st_overflow, 1);
    do_flush();
    chk(st_overflow == 0, "R6", st_overflow, 0);

    // R1 flush discards stored data
    wr_frame(3, 8'h77); accept();
    do_flush();
    chk(st_nonempty == 0 && rd_data == 0, "R1", st_nonempty, 0);
    chk(dma_req == 0, "R1", dma_req, 0);

    // R7 threshold on occupancy and on whole frames
    thresh = 8'd5;
    wr_frame(4, 8'h90);
    chk(st_thresh == 0, "R7", st_thresh, 0);
    wr(8'h94);
    chk(st_thresh == 1, "R7", st_thresh, 1);
    reject();
    chk(st_thresh == 0, "R7", st_thresh, 0);
    wr_frame(2, 8'hB0); accept();
    chk(st_thresh == 1, "R7", st_thresh, 1);
    rd_n(1, "R7");
    chk(st_thresh == 1, "R7", st_thresh, 1);
    rd_n(1, "R7");
    chk(st_thresh == 0, "R7", st_thresh, 0);
    thresh = 0;

    // R9 read while empty leaves nothing changed
    rd_en = 1; cyc(); rd_en = 0;
    chk(st_nonempty == 0 && rd_data == 0 && dma_req == 0, "R9", rd_data, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule